// File: doc/BRIEF.md
# SDRAM Refresh Scheduler

This block decides when an SDRAM memory controller must send auto-refresh commands. A free-running interval timer counts controller clock cycles. Each time it expires, one more refresh is owed. The device keeps its own row pointer, so the scheduler never produces a row address. It only has to issue one command per owed refresh. When a refresh is owed and the memory is quiet, the scheduler asks the command arbiter for the bus. Once granted, it closes every bank with a precharge-all command, waits the precharge time, and sends auto-refresh. It then holds off normal traffic until the refresh cycle time has passed.

When the device runs hot, the interval is halved. While the memory is busy, refreshes are deferred and tracked as a debt. When the debt reaches its ceiling, the request turns urgent and ignores busy. When the memory goes quiet and the arbiter grants access, the owed refreshes are paid back one sequence after another.

Top module: `refresh_sched`

## Requirements
- R1: The interval timer expires once every FULL_CYC enabled cycles at normal temperature. After reset, the first refresh is owed FULL_CYC cycles after reset is released.
- R2: While `hot` is 1, the interval is FULL_CYC/2 cycles. The flag is sampled only when the timer reloads: at reset or at expiry.
- R3: A granted request produces a one-cycle `pre_all` pulse on the cycle after the grant. A one-cycle `auto_ref` pulse follows exactly T_RP cycles after `pre_all`.
- R4: `stall` is 1 from the `pre_all` cycle through T_RP+T_RFC consecutive cycles, and 0 otherwise.
- R5: While `busy` is 1 and the debt is below DEBT_MAX, `req` stays 0. Each timer expiry still adds one owed refresh.
- R6: With `busy` 0 and `grant` 1, owed refreshes are issued back to back. The `pre_all` pulses are T_RP+T_RFC+1 cycles apart until the debt is zero.
- R7: When the debt equals DEBT_MAX, `urgent` is 1 and `req` is raised even while `busy` is 1.
- R8: The debt saturates at DEBT_MAX. Expiries that arrive at the ceiling are dropped, unless a refresh is issued in the same cycle.
- R9: No command starts without `req` and `grant` in the previous cycle. While the grant is withheld, `req` stays raised.
- R10: While `en` is 0, the timer is frozen and `req` is 0. A command sequence already under way runs to completion.
- R11: Synchronous active-high `rst` clears the debt, reloads the timer and returns the sequencer to idle. During reset, all outputs are 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Controller clock |
| rst | input | 1 | Synchronous active-high reset |
| en | input | 1 | Scheduler enable |
| hot | input | 1 | High-temperature flag; halves the interval |
| busy | input | 1 | Memory has normal traffic pending |
| grant | input | 1 | Arbiter grants the command bus |
| req | output | 1 | Refresh request to the arbiter |
| urgent | output | 1 | Debt at its ceiling; request overrides busy |
| pre_all | output | 1 | Precharge-all command pulse |
| auto_ref | output | 1 | Auto-refresh command pulse |
| stall | output | 1 | Block normal accesses |

## Verification
The properties assume that the arbiter raises `grant` only as a response the scheduler can act on. A grant seen while `req` is low must start nothing. The properties also assume that `busy` and `en` may change on any cycle. The stimulus holds `grant` high for whole phases, or low for whole phases, to test deferral. It toggles `busy`, `hot` and `en` only between clock edges. Flag changes are placed well before or after a reload, so that the reload that samples them is unambiguous.

// File: rtl/refsch_pkg.sv
package refsch_pkg;
   typedef enum logic [2:0] {
      RS_IDLE = 3'd0,
      RS_PRE  = 3'd1,
      RS_RPW  = 3'd2,
      RS_REF  = 3'd3,
      RS_RFCW = 3'd4
   } rs_state_t;
endpackage

// File: rtl/refsch_timer.sv
module refsch_timer #(
   parameter int FULL_CYC = 780
) (
   input  logic clk,
   input  logic rst,
   input  logic en,
   input  logic hot,
   output logic tick
);
   localparam int HALF_CYC = FULL_CYC / 2;
   localparam int W = $clog2(FULL_CYC);
   localparam logic [W-1:0] RLD_N = W'(FULL_CYC - 1);
   localparam logic [W-1:0] RLD_H = W'(HALF_CYC - 1);

   logic [W-1:0] tmr;
   logic [W-1:0] rld;

   assign rld  = hot ? RLD_H : RLD_N;
   assign tick = en && (tmr == '0);

   always_ff @(posedge clk) begin
      if (rst)
         tmr <= rld;
      else if (en) begin
         if (tmr == '0)
            tmr <= rld;
         else
            tmr <= tmr - 1'b1;
      end
   end
endmodule

// File: rtl/refsch_debt.sv
module refsch_debt #(
   parameter int DEBT_MAX = 8
) (
   input  logic clk,
   input  logic rst,
   input  logic tick,
   input  logic issue,
   output logic owed,
   output logic full
);
   generate
      if (DEBT_MAX == 1) begin : g_flag
         logic pend;
         always_ff @(posedge clk) begin
            if (rst)
               pend <= 1'b0;
            else if (tick)
               pend <= 1'b1;
            else if (issue)
               pend <= 1'b0;
         end
         assign owed = pend;
         assign full = pend;
      end else begin : g_cnt
         localparam int DW = $clog2(DEBT_MAX + 1);
         localparam logic [DW-1:0] CEIL = DW'(DEBT_MAX);
         logic [DW-1:0] cnt;
         logic          inc;
         assign inc = tick && ((cnt != CEIL) || issue);
         always_ff @(posedge clk) begin
            if (rst)
               cnt <= '0;
            else begin
               case ({inc, issue})
                  2'b10:   cnt <= cnt + 1'b1;
                  2'b01:   cnt <= cnt - 1'b1;
                  default: cnt <= cnt;
               endcase
            end
         end
         assign owed = (cnt != '0);
         assign full = (cnt == CEIL);
      end
   endgenerate
endmodule

// File: rtl/refsch_seq.sv
module refsch_seq
   import refsch_pkg::*;
#(
   parameter int T_RP  = 3,
   parameter int T_RFC = 28
) (
   input  logic clk,
   input  logic rst,
   input  logic start,
   output logic idle,
   output logic pre_all,
   output logic auto_ref,
   output logic stall
);
   localparam int WMAX = (T_RP > T_RFC) ? T_RP : T_RFC;
   localparam int WW   = (WMAX > 2) ? $clog2(WMAX) : 1;
   localparam logic [WW-1:0] LD_RP  = WW'(T_RP - 2);
   localparam logic [WW-1:0] LD_RFC = WW'(T_RFC - 2);

   rs_state_t     st;
   logic [WW-1:0] wcnt;

   always_ff @(posedge clk) begin
      if (rst) begin
         st   <= RS_IDLE;
         wcnt <= '0;
      end else begin
         case (st)
            RS_IDLE: if (start) st <= RS_PRE;
            RS_PRE: begin
               st   <= RS_RPW;
               wcnt <= LD_RP;
            end
            RS_RPW: begin
               if (wcnt == '0) st <= RS_REF;
               else            wcnt <= wcnt - 1'b1;
            end
            RS_REF: begin
               st   <= RS_RFCW;
               wcnt <= LD_RFC;
            end
            RS_RFCW: begin
               if (wcnt == '0) st <= RS_IDLE;
               else            wcnt <= wcnt - 1'b1;
            end
            default: st <= RS_IDLE;
         endcase
      end
   end

   assign idle     = (st == RS_IDLE);
   assign pre_all  = (st == RS_PRE);
   assign auto_ref = (st == RS_REF);
   assign stall    = (st != RS_IDLE);
endmodule

// File: rtl/refresh_sched.sv
module refresh_sched #(
   parameter int FULL_CYC = 780,
   parameter int T_RP     = 3,
   parameter int T_RFC    = 28,
   parameter int DEBT_MAX = 8
) (
   input  logic clk,
   input  logic rst,
   input  logic en,
   input  logic hot,
   input  logic busy,
   input  logic grant,
   output logic req,
   output logic urgent,
   output logic pre_all,
   output logic auto_ref,
   output logic stall
);
   generate
      if (FULL_CYC < 4) begin : g_bad_int
         $error("refresh_sched: FULL_CYC must be at least 4");
      end
      if (T_RP < 2 || T_RFC < 2) begin : g_bad_wait
         $error("refresh_sched: T_RP and T_RFC must be at least 2");
      end
      if (DEBT_MAX < 1) begin : g_bad_debt
         $error("refresh_sched: DEBT_MAX must be at least 1");
      end
   endgenerate

   logic tick, owed, full, idle, start;

   refsch_timer #(.FULL_CYC(FULL_CYC)) u_tmr (
      .clk(clk), .rst(rst), .en(en), .hot(hot), .tick(tick)
   );

   refsch_debt #(.DEBT_MAX(DEBT_MAX)) u_debt (
      .clk(clk), .rst(rst), .tick(tick), .issue(auto_ref),
      .owed(owed), .full(full)
   );

   refsch_seq #(.T_RP(T_RP), .T_RFC(T_RFC)) u_seq (
      .clk(clk), .rst(rst), .start(start), .idle(idle),
      .pre_all(pre_all), .auto_ref(auto_ref), .stall(stall)
   );

   assign urgent = full;
   assign req    = en && idle && owed && (!busy || full);
   assign start  = req && grant;
endmodule

// File: rtl/refsch_chk.sv
module refsch_chk #(
   parameter int T_RP  = 3,
   parameter int T_RFC = 28
) (
   input logic clk,
   input logic rst,
   input logic en,
   input logic busy,
   input logic grant,
   input logic req,
   input logic urgent,
   input logic pre_all,
   input logic auto_ref,
   input logic stall
);
   localparam int CAP = T_RP + T_RFC + 1;
   localparam int CW  = $clog2(CAP + 1);
   localparam logic [CW-1:0] CAPV = CW'(CAP);

   logic [CW-1:0] since_pre;
   always_ff @(posedge clk) begin
      if (rst)
         since_pre <= CAPV;
      else if (pre_all)
         since_pre <= CW'(1);
      else if (since_pre != CAPV)
         since_pre <= since_pre + 1'b1;
   end

   // R3
   rp_gap_chk: assert property (@(posedge clk) disable iff (rst)
      auto_ref |-> (since_pre == CW'(T_RP)));
   // R3
   pre_single_chk: assert property (@(posedge clk) disable iff (rst)
      pre_all |=> !pre_all);
   // R4
   stall_cover_chk: assert property (@(posedge clk) disable iff (rst)
      (pre_all || auto_ref) |-> stall);
   // R4
   stall_end_chk: assert property (@(posedge clk) disable iff (rst)
      $fell(stall) |-> (since_pre == CW'(T_RP + T_RFC)));
   // R9
   pre_granted_chk: assert property (@(posedge clk) disable iff (rst)
      pre_all |-> $past(req && grant));
   // R7
   urgent_req_chk: assert property (@(posedge clk) disable iff (rst)
      (urgent && !stall && en) |-> req);
   // R5
   busy_hold_chk: assert property (@(posedge clk) disable iff (rst)
      (busy && !urgent) |-> !req);
   // R10
   off_quiet_chk: assert property (@(posedge clk) disable iff (rst)
      !en |-> !req);
endmodule

bind refresh_sched refsch_chk #(.T_RP(T_RP), .T_RFC(T_RFC)) u_chk (
   .clk(clk), .rst(rst), .en(en), .busy(busy), .grant(grant),
   .req(req), .urgent(urgent), .pre_all(pre_all),
   .auto_ref(auto_ref), .stall(stall)
);

// File: tb/refresh_sched_bench.sv
module refresh_sched_bench;
   localparam int CLK_NS = 10;
   localparam int L      = 40;
   localparam int TRP    = 3;
   localparam int TRFC   = 6;
   localparam int DM     = 4;

   logic clk = 1'b0;
   logic rst = 1'b1;
   logic en = 1'b0, hot = 1'b0, busy = 1'b0, grant = 1'b0;
   logic req, urgent, pre_all, auto_ref, stall;

   int total = 0;
   int bad = 0;
   int cyc = 0;
   int last_pre = -100;
   bit done = 1'b0;
   string tag = "R1";
   int exp_q[$];

   always #(CLK_NS/2) clk = ~clk;

   refresh_sched #(.FULL_CYC(L), .T_RP(TRP), .T_RFC(TRFC), .DEBT_MAX(DM)) u_refresh_sched (
      .clk(clk), .rst(rst), .en(en), .hot(hot), .busy(busy), .grant(grant),
      .req(req), .urgent(urgent), .pre_all(pre_all),
      .auto_ref(auto_ref), .stall(stall)
   );

   always @(posedge clk) begin
      if (rst) cyc <= 0;
      else     cyc <= cyc + 1;
   end

   task automatic chk(input bit ok, input string r, input int act, input int exp);
      total++;
      if (!ok) begin
         bad++;
         $display("FAIL %s cyc=%0d actual=%0d expected=%0d", r, cyc, act, exp);
      end
   endtask

   // monitor: pops expected refresh cycles as the design issues them
   always @(negedge clk) begin
      if (!rst) begin
         if (pre_all) last_pre = cyc;
         if (auto_ref) begin
            // R3 gap from precharge
            chk(cyc - last_pre == TRP, "R3", cyc - last_pre, TRP);
            if (exp_q.size() == 0)
               chk(1'b0, tag, cyc, -1);
            else begin
               int e;
               e = exp_q.pop_front();
               chk(cyc == e, tag, cyc, e);
            end
         end
      end
   end

   task automatic at(input int n);
      while (cyc < n) @(negedge clk);
   endtask

   task automatic do_reset(input logic h, input logic g, input logic b);
      @(negedge clk);
      rst = 1'b1; en = 1'b1; hot = h; grant = g; busy = b;
      repeat (2) @(negedge clk);
      // R11 reset state
      chk({req, urgent, pre_all, auto_ref, stall} == 5'b0, "R11",
          int'({req, urgent, pre_all, auto_ref, stall}), 0);
      rst = 1'b0;
   endtask

   task automatic end_scen();
      chk(exp_q.size() == 0, tag, exp_q.size(), 0);
      exp_q.delete();
   endtask

   initial begin
      // Scenario 1: normal interval, sequence and stall window
      do_reset(1'b0, 1'b1, 1'b0);
      tag = "R1";
      exp_q.push_back(44); exp_q.push_back(84); exp_q.push_back(124);
      at(39); chk(req == 1'b0, "R1", req, 0);
      at(40); chk(req == 1'b1, "R1", req, 1);
              chk(stall == 1'b0, "R4", stall, 0);
      at(41); chk(pre_all == 1'b1, "R3", pre_all, 1);
              chk(stall == 1'b1, "R4", stall, 1);
      at(49); chk(stall == 1'b1, "R4", stall, 1);
      at(50); chk(stall == 1'b0, "R4", stall, 0);
      at(130); end_scen();

      // Scenario 2: hot interval, flag change taken at reload
      do_reset(1'b1, 1'b1, 1'b0);
      tag = "R2";
      exp_q.push_back(24); exp_q.push_back(44); exp_q.push_back(64); exp_q.push_back(104);
      at(50); hot = 1'b0;
      at(110); end_scen();

      // Scenario 3: busy defers, then back-to-back catch-up
      do_reset(1'b0, 1'b1, 1'b1);
      tag = "R6";
      exp_q.push_back(134); exp_q.push_back(144); exp_q.push_back(154); exp_q.push_back(164);
      at(125); chk(req == 1'b0, "R5", req, 0);
      at(130); busy = 1'b0;
      at(131); chk(pre_all == 1'b1, "R6", pre_all, 1);
      at(141); chk(pre_all == 1'b1, "R6", pre_all, 1);
      at(170); end_scen();

      // Scenario 4: urgent overrides busy at the ceiling
      do_reset(1'b0, 1'b1, 1'b1);
      tag = "R7";
      exp_q.push_back(164); exp_q.push_back(204);
      at(159); chk(urgent == 1'b0, "R7", urgent, 0);
      at(160); chk(urgent == 1'b1, "R7", urgent, 1);
               chk(req == 1'b1, "R7", req, 1);
      at(166); chk(urgent == 1'b0, "R7", urgent, 0);
      at(210); end_scen();

      // Scenario 5: grant withheld, saturation, enable freeze
      do_reset(1'b0, 1'b0, 1'b0);
      tag = "R8";
      at(45);  chk(req == 1'b1, "R9", req, 1);
      at(200); chk(urgent == 1'b1, "R8", urgent, 1);
      at(210); en = 1'b0; grant = 1'b1;
      at(250); chk(req == 1'b0, "R10", req, 0);
      exp_q.push_back(304); exp_q.push_back(314); exp_q.push_back(324);
      exp_q.push_back(334); exp_q.push_back(344); exp_q.push_back(374);
      at(300); en = 1'b1;
      at(380); end_scen();

      // Scenario 6: enable dropped mid-sequence
      do_reset(1'b0, 1'b1, 1'b0);
      tag = "R10";
      exp_q.push_back(44);
      at(42); en = 1'b0;
      at(49); chk(stall == 1'b1, "R10", stall, 1);
      at(50); chk(stall == 1'b0, "R10", stall, 0);
      at(100); chk(req == 1'b0, "R10", req, 0);
      end_scen();

      done = 1'b1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      #(CLK_NS * 20000);
      if (!done) begin
         total++; bad++;
         $display("FAIL watchdog cyc=%0d actual=hung expected=done", cyc);
         $display("test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end
endmodule